// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous memory. The address, the operation type, the byte-lane write selects and the three chip selects are captured on a rising clock edge. The data transfer for that operation takes place during the following clock cycle. Because the data phase is always one cycle behind its command, a read may directly follow a write, and a write may directly follow a read, with no idle bus cycle between them. Read data is not registered. The addressed array word drives the bidirectional data bus combinationally for the whole data cycle.

A load/advance control chooses between two actions. Low loads a fresh external address. High steps an internal two-bit burst offset, so that one address can supply a sequence of four words. A static mode input selects a linear or an interleaved order for that sequence. An active-low clock enable freezes the whole pipeline, including any pending transfer and the burst position. An asynchronous output enable can release the bus at any moment. The word is 36 bits wide and is split into four 9-bit lanes. Each lane can be written on its own.

Top module: `zbt_sram`

## Requirements
- R1: With `clk_en_n` low and `ld_n` low, a rising edge captures `addr`, `rd_wr` and `be_n`. The read or write they describe is carried out during the next clock cycle. A read captured on the edge that ends a write data cycle, at the same address, returns the newly written word.
- R2: During the data cycle of a read, with `out_en_n` low, `dq` carries the word stored at the captured address. It is driven combinationally from the array and is not held in an output register.
- R3: While `out_en_n` is high, the block does not drive `dq`, whatever the state of the pipeline. The bus returns to read data as soon as `out_en_n` falls again.
- R4: On an edge where `clk_en_n` is high, every input sampled on that edge is ignored and every internal register keeps its value, including any pending transfer and the burst position. A stalled pending write is committed on the first enabled edge, using the data present on `dq` at that edge.
- R5: A load (`ld_n` low) starts an operation only if `sel1_n` is low, `sel2` is high and `sel3_n` is low. Any other combination deselects the block and starts nothing. An operation captured on the previous edge still completes.
- R6: `dq` is not driven by the block after reset, in the cycle after a deselect, or during the data cycle of any write.
- R7: `ld_n` high advances the burst, and the new beat keeps the read/write type of the load that opened the burst. The `rd_wr` input is ignored on advance cycles. An advance when no burst is open (after reset or after a deselect) starts no transfer.
- R8: Only address bits [1:0] change within a burst. On beat n (0 to 3) the offset is (start + n) mod 4 when `burst_ilv` is 0, and start XOR n when `burst_ilv` is 1. After the fourth beat, further advances wrap around to beat 0.
- R9: Lane i is `dq[9*i+8:9*i]`. A write updates lane i only when `be_n[i]` was low on the edge that captured that beat. Lanes that are not selected keep their old contents.
- R10: `rd_wr` equal to 1 selects a read and 0 selects a write. Any order of reads and writes runs at one operation per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low: load new address; high: advance burst |
| rd_wr | input | 1 | 1 = read, 0 = write |
| be_n | input | 4 | Active-low lane write selects |
| addr | input | AW | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | 36 | Bidirectional data bus |

## Verification
If the pending data-phase state is wrong, the error shows at the ports in the very next cycle. The bus is released when it should carry read data, or it carries a word from the wrong address, or a write lands in a cell that a later read then exposes. If the burst offset or the inherited operation type is wrong, the first advance beat that uses it shows a wrong word or a floating bus. If the stall logic lets a register move, the word on the bus changes while the clock enable is high. A broken lane mask shows up as mixed old and new lanes on the next read of the same address.

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             ld_n,
  input  logic             rd_wr,
  input  logic [LANES-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic             burst_ilv,
  input  logic             out_en_n,
  inout  wire  [LANES*LW-1:0] dq
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             ph_valid, ph_write;
  logic [AW-1:0]    ph_addr;
  logic [LANES-1:0] ph_be_n;
  logic             bst_act, bst_wr;
  logic [AW-1:0]    bst_base;
  logic [1:0]       bst_cnt;

  wire       all_sel = ~sel1_n & sel2 & ~sel3_n;
  wire [1:0] nxt_cnt = bst_cnt + 2'd1;
  wire [1:0] nxt_off = burst_ilv ? (bst_base[1:0] ^ nxt_cnt)
                                 : (bst_base[1:0] + nxt_cnt);
  wire       drv_en  = ph_valid & ~ph_write & ~out_en_n;

  assign dq = drv_en ? mem[ph_addr] : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_valid <= 1'b0;
      ph_write <= 1'b0;
      ph_addr  <= '0;
      ph_be_n  <= '1;
      bst_act  <= 1'b0;
      bst_wr   <= 1'b0;
      bst_base <= '0;
      bst_cnt  <= 2'd0;
    end else if (!clk_en_n) begin
      ph_be_n <= be_n;
      if (!ld_n) begin
        ph_valid <= all_sel;
        bst_act  <= all_sel;
        ph_write <= ~rd_wr;
        bst_wr   <= ~rd_wr;
        ph_addr  <= addr;
        bst_base <= addr;
        bst_cnt  <= 2'd0;
      end else begin
        ph_valid <= bst_act;
        ph_write <= bst_wr;
        if (bst_act) begin
          bst_cnt <= nxt_cnt;
          ph_addr <= {bst_base[AW-1:2], nxt_off};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!clk_en_n && ph_valid && ph_write) begin
      for (int i = 0; i < LANES; i++) begin
        if (!ph_be_n[i]) mem[ph_addr][i*LW +: LW] <= dq[i*LW +: LW];
      end
    end
  end
endmodule

module zbt_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel1_n,
  input logic          sel2,
  input logic          sel3_n,
  input logic          ld_n,
  input logic          rd_wr,
  input logic          burst_ilv,
  input logic [AW-1:0] addr,
  input logic          ph_valid,
  input logic          ph_write,
  input logic [AW-1:0] ph_addr,
  input logic          bst_act,
  input logic [1:0]    bst_cnt,
  input logic          drv_en
);
  wire sel_ok = !sel1_n && sel2 && !sel3_n;
  wire adv    = !clk_en_n && ld_n && bst_act && ph_valid;

  p_load_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && sel_ok) |=>
      (ph_valid && ph_addr == $past(addr) && ph_write == !$past(rd_wr)));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(ph_valid) && $stable(ph_write) && $stable(ph_addr)
                  && $stable(bst_act) && $stable(bst_cnt)));

  p_deselect_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && !sel_ok) |=> !ph_valid);

  p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && !sel_ok) |=> !drv_en);

  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && sel_ok && !rd_wr) |=> !drv_en);

  p_adv_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ph_valid && ph_write == $past(ph_write)));

  p_burst_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ph_addr[AW-1:2] == $past(ph_addr[AW-1:2])));

  p_linear_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !burst_ilv) |=> (ph_addr[1:0] == $past(ph_addr[1:0]) + 2'd1));
endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n),
  .sel2(sel2), .sel3_n(sel3_n), .ld_n(ld_n), .rd_wr(rd_wr),
  .burst_ilv(burst_ilv), .addr(addr), .ph_valid(ph_valid),
  .ph_write(ph_write), .ph_addr(ph_addr), .bst_act(bst_act),
  .bst_cnt(bst_cnt), .drv_en(drv_en)
);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/100ps
module zbt_sram_bench;
  localparam int AW = 6;
  localparam logic [35:0] ZV = {36{1'b1}};
  localparam logic [2:0] OK = 3'b010;
  localparam logic [1:0] KZ = 2'd0, KR = 2'd1, KW = 2'd2;

  typedef struct packed {
    logic ld; logic rd; logic [2:0] cs; logic [3:0] be; logic ilv;
    logic [5:0] a; logic [1:0] kind; logic [35:0] d; logic [3:0] req;
  } vec_t;

  localparam int N = 31;
  localparam vec_t VEC [N] = '{
    '{0,0,OK,4'h0,0,6'h08,KW,36'h123456789,4'd1},   // R1 write
    '{0,1,OK,4'h0,0,6'h08,KR,36'h123456789,4'd1},   // R1 read right after write
    '{0,0,OK,4'h0,0,6'h09,KW,36'h0AAAA5555,4'd10},  // R10 read then write
    '{0,0,OK,4'h0,0,6'h0A,KW,36'h033334444,4'd10},
    '{0,0,OK,4'h0,0,6'h0B,KW,36'h077778888,4'd10},
    '{0,1,OK,4'h0,0,6'h09,KR,36'h0AAAA5555,4'd2},   // R2 flow-through read
    '{0,0,OK,4'hA,0,6'h08,KW,36'h000000000,4'd9},   // R9 lanes 0,2 only
    '{0,1,OK,4'h0,0,6'h08,KR,36'h120016600,4'd9},
    '{0,1,3'b000,4'h0,0,6'h08,KZ,36'h0,4'd5},       // R5 sel2 low
    '{0,1,3'b110,4'h0,0,6'h09,KZ,36'h0,4'd5},       // R5 sel1_n high
    '{0,1,3'b011,4'h0,0,6'h09,KZ,36'h0,4'd5},       // R5 sel3_n high
    '{0,1,OK,4'h0,0,6'h0A,KR,36'h033334444,4'd8},   // R8 linear from 2
    '{1,0,OK,4'h0,0,6'h3F,KR,36'h077778888,4'd7},   // R7 inherits read
    '{1,0,OK,4'h0,0,6'h3F,KR,36'h120016600,4'd8},
    '{1,0,OK,4'h0,0,6'h3F,KR,36'h0AAAA5555,4'd8},
    '{0,1,OK,4'h0,1,6'h09,KR,36'h0AAAA5555,4'd8},   // R8 interleaved from 1
    '{1,0,OK,4'h0,1,6'h3F,KR,36'h120016600,4'd8},
    '{1,0,OK,4'h0,1,6'h3F,KR,36'h077778888,4'd8},
    '{1,0,OK,4'h0,1,6'h3F,KR,36'h033334444,4'd8},
    '{0,0,OK,4'h0,1,6'h12,KW,36'h000000012,4'd7},   // R7 write burst
    '{1,1,OK,4'h0,1,6'h3F,KW,36'h000000013,4'd7},
    '{1,1,OK,4'h0,1,6'h3F,KW,36'h000000010,4'd7},
    '{1,1,OK,4'h0,1,6'h3F,KW,36'h000000011,4'd7},
    '{0,1,OK,4'h0,0,6'h10,KR,36'h000000010,4'd8},
    '{1,1,OK,4'h0,0,6'h3F,KR,36'h000000011,4'd8},
    '{1,1,OK,4'h0,0,6'h3F,KR,36'h000000012,4'd8},
    '{1,1,OK,4'h0,0,6'h3F,KR,36'h000000013,4'd8},
    '{1,1,OK,4'h0,0,6'h3F,KR,36'h000000010,4'd8},   // R8 wrap
    '{0,1,3'b000,4'h0,0,6'h00,KZ,36'h0,4'd6},       // R6 after deselect
    '{1,1,OK,4'h0,0,6'h00,KZ,36'h0,4'd7},           // R7 advance, no burst
    '{0,0,OK,4'h0,0,6'h08,KZ,36'h0,4'd6}            // R6 write data cycle
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, clk_en_n, sel1_n, sel2, sel3_n, ld_n, rd_wr, burst_ilv, out_en_n;
  logic [3:0] be_n;
  logic [AW-1:0] addr;
  logic tb_oe;
  logic [35:0] tb_wd;
  wire  [35:0] dq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  for (genvar g = 0; g < 36; g++) begin : g_pu
    pullup (dq[g]);
  end
  assign dq = tb_oe ? tb_wd : {36{1'bz}};

  zbt_sram #(.AW(AW)) u_zbt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n),
    .sel2(sel2), .sel3_n(sel3_n), .ld_n(ld_n), .rd_wr(rd_wr), .be_n(be_n),
    .addr(addr), .burst_ilv(burst_ilv), .out_en_n(out_en_n), .dq(dq)
  );

  task automatic chk(input string req, input logic [35:0] exp);
    n_chk++;
    if (dq !== exp) begin
      n_bad++;
      $display("FAIL %s: dq=%h expected %h at %0t", req, dq, exp, $time);
    end
  endtask

  task automatic cmd(input logic ld, input logic rd, input logic [2:0] cs,
                     input logic [3:0] be, input logic ilv, input logic [AW-1:0] a);
    ld_n = ld; rd_wr = rd; {sel1_n, sel2, sel3_n} = cs;
    be_n = be; burst_ilv = ilv; addr = a;
  endtask

  task automatic idle();
    cmd(1'b0, 1'b1, 3'b000, 4'hF, 1'b0, '0);
  endtask

  initial begin
    rst_n = 0; clk_en_n = 0; out_en_n = 0; tb_oe = 0; tb_wd = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmd(1'b1, 1'b0, OK, 4'h0, 1'b0, '0);            // advance right after reset
    #1 chk("R6 reset", ZV);
    @(negedge clk); idle();
    #1 chk("R7 advance after reset", ZV);

    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      if (i > 0 && VEC[i-1].kind == KW) begin
        tb_wd = VEC[i-1].d; tb_oe = 1;
      end else tb_oe = 0;
      if (i < N) cmd(VEC[i].ld, VEC[i].rd, VEC[i].cs, VEC[i].be, VEC[i].ilv, VEC[i].a);
      else idle();
      #1;
      if (i > 0 && VEC[i-1].kind != KW) begin
        n_chk++;
        if (dq !== ((VEC[i-1].kind == KR) ? VEC[i-1].d : ZV)) begin
          n_bad++;
          $display("FAIL R%0d vec %0d: dq=%h expected %h", VEC[i-1].req, i-1, dq,
                   (VEC[i-1].kind == KR) ? VEC[i-1].d : ZV);
        end
      end
    end

    // R4: stalled write commits data present at the first enabled edge
    @(negedge clk); cmd(1'b0, 1'b0, OK, 4'h0, 1'b0, 6'h20);
    @(negedge clk); tb_oe = 1; tb_wd = 36'h011110001; clk_en_n = 1;
    cmd(1'b0, 1'b1, OK, 4'h0, 1'b0, 6'h08);
    @(negedge clk); tb_wd = 36'h00BEEF002; clk_en_n = 0; idle();
    @(negedge clk); tb_oe = 0; cmd(1'b0, 1'b1, OK, 4'h0, 1'b0, 6'h20);
    #1 chk("R5 deselect after stall", ZV);
    @(negedge clk); clk_en_n = 1; cmd(1'b0, 1'b1, OK, 4'h0, 1'b0, 6'h08);
    #1 chk("R4 stalled write committed", 36'h00BEEF002);
    @(negedge clk); clk_en_n = 0; idle();
    #1 chk("R4 read held through stall", 36'h00BEEF002);
    @(negedge clk);
    #1 chk("R6 after stall deselect", ZV);

    // R3: asynchronous output enable
    @(negedge clk); cmd(1'b0, 1'b1, OK, 4'h0, 1'b0, 6'h20);
    @(negedge clk); idle();
    #1 chk("R2 read before oe test", 36'h00BEEF002);
    out_en_n = 1;
    #0.5 chk("R3 oe high releases bus", ZV);
    out_en_n = 0;
    #0.2 chk("R3 oe low restores data", 36'h00BEEF002);
    @(negedge clk);
    #1 chk("R6 idle end", ZV);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1;
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule